// File: doc/BRIEF.md
# Partitioned Ternary CAM Array

This block is a small content-addressable memory. It holds a parameterized number of 64-bit entries, and each entry has a two-bit validity tag. A compare strobe checks a 64-bit key against every entry in the same cycle. One clock later the block reports a hit flag, a multiple-hit flag and the index of the lowest-numbered hitting entry. The block also always shows the lowest-numbered empty entry and a full flag.

A control register holds two settings. The first is a partition code that splits every word into a searchable part and a stored-only part, in 16-bit segments, with the stored-only part at either end of the word. The second chooses which of two mask registers, if either, hides bits from a compare. A compare names the validity condition an entry must carry in order to hit. Writes choose their target in one of four ways: an explicit index, an internal address register, the next empty entry, or the last hit index. Either mask register can protect bits from a write. Reads by index are combinational.

Top module: `tcam_array`

## Requirements
- R1: After reset every entry reads validity 01 (empty) with data zero, free_addr_o is 0, full_o and match_o are low, the control register is all-searchable with no compare mask, and both mask registers and the address register are zero.
- R2: The validity tag is {skip, empty}: 00 valid, 01 empty, 10 skip, 11 stored-only. An entry can hit only when its tag equals cmp_cond_i, which uses the same code. A compare on condition 00 therefore never hits skip, empty or stored-only entries.
- R3: match_o, multi_o and hpm_addr_o update on the clock edge that samples cmp_i. hpm_addr_o is the lowest hitting index, and multi_o is high when two or more entries hit.
- R4: With cmp_i and wr_i low, the results hold. A write without a compare clears match_o and multi_o and sets hpm_addr_o to 0.
- R5: Control mask select 00 or 11 uses no compare mask, 01 uses mask A and 10 uses mask B. A mask bit of 1 excludes that data bit from the compare.
- R6: Partition code bits [1:0] give the number of 16-bit stored-only segments. Bit 2 = 0 places them at the low end and bit 2 = 1 at the high end. Stored-only bits never take part in a compare, and reads still return them. For example, code 001 searches bits [63:16].
- R7: A compare on condition 01 (empty) ignores every data bit, whatever the mask and partition settings, and hits every empty entry.
- R8: wr_src_i selects the write index: 00 wr_addr_i, 01 the address register, 10 free_addr_o, 11 hpm_addr_o. A write stores wr_vb_i as the new tag.
- R9: A write from source 10 while full_o is high, or from source 11 while match_o is low, changes no entry.
- R10: wr_msel_i 01 selects mask A and 10 selects mask B as a write mask. Bits where the selected mask is 1 keep their old value. 00 and 11 write all bits.
- R11: free_addr_o is the lowest empty index and full_o is high when no entry is empty. Both follow the array in the cycle after a write edge.
- R12: rd_data_o and rd_vb_o show the entry at rd_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Load control register |
| ctrl_part_i | input | 3 | Partition code |
| ctrl_msel_i | input | 2 | Compare mask select |
| mask_we_i | input | 1 | Load a mask register |
| mask_sel_i | input | 1 | 0 mask A, 1 mask B |
| mask_data_i | input | 64 | Mask value |
| areg_we_i | input | 1 | Load address register |
| areg_i | input | AW | Address register value |
| wr_i | input | 1 | Write strobe |
| wr_src_i | input | 2 | Write index source |
| wr_addr_i | input | AW | Explicit write index |
| wr_data_i | input | 64 | Write data |
| wr_vb_i | input | 2 | Validity tag to store |
| wr_msel_i | input | 2 | Write mask select |
| rd_addr_i | input | AW | Read index |
| rd_data_o | output | 64 | Read data |
| rd_vb_o | output | 2 | Read validity tag |
| cmp_i | input | 1 | Compare strobe |
| cmp_cond_i | input | 2 | Validity condition for compare |
| cmp_key_i | input | 64 | Compare key |
| match_o | output | 1 | At least one hit |
| multi_o | output | 1 | Two or more hits |
| hpm_addr_o | output | AW | Lowest hitting index |
| free_addr_o | output | AW | Lowest empty index |
| full_o | output | 1 | No empty entry |

## Verification
The bench places a duplicate key at a higher index than the first copy. A priority encoder that picked the wrong end would then report the later index, and a broken multi-hit detector would leave multi_o low. It hides the differing bits of a key in turn behind each mask, each partition code and each end of the word, so a partition decoded from the wrong end of the word would miss or hit the wrong way. It stores skip and stored-only entries whose data matches a valid-condition key, so that a design that ignores the tag hits on them. It also chains writes by last-hit index and by next-free index into the full state, where a design that does not drop those writes would overwrite an entry that reads back with a known value.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    VB_VALID = 2'b00,
    VB_EMPTY = 2'b01,
    VB_SKIP  = 2'b10,
    VB_RAM   = 2'b11
  } vbits_e;

  typedef enum logic [1:0] {
    WA_EXPLICIT = 2'b00,
    WA_AREG     = 2'b01,
    WA_FREE     = 2'b10,
    WA_HPM      = 2'b11
  } wsrc_e;

  typedef enum logic [1:0] {
    MS_NONE = 2'b00,
    MS_A    = 2'b01,
    MS_B    = 2'b10,
    MS_RSVD = 2'b11
  } msel_e;
endpackage

// File: rtl/tcam_part_mask.sv
module tcam_part_mask #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16
) (
  input  logic [2:0]        part_i,
  output logic [DATA_W-1:0] care_o
);
  localparam int SEGS = DATA_W / SEG_W;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic ram_seg;
    always_comb begin
      if (part_i[2]) ram_seg = (s >= SEGS - int'(part_i[1:0]));
      else           ram_seg = (s < int'(part_i[1:0]));
    end
    assign care_o[s*SEG_W +: SEG_W] = {SEG_W{~ram_seg}};
  end
endmodule

// File: rtl/tcam_match_line.sv
module tcam_match_line #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] entry_i,
  input  logic [1:0]        vb_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic [DATA_W-1:0] ign_i,
  input  logic [1:0]        cond_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] diff;
  assign diff  = (entry_i ^ key_i) & ~ign_i;
  assign hit_o = (vb_i == cond_i) && (diff == '0);
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [AW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int DATA_W    = 64,
  parameter int SEG_W     = 16,
  localparam int AW       = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [2:0]        ctrl_part_i,
  input  logic [1:0]        ctrl_msel_i,
  input  logic              mask_we_i,
  input  logic              mask_sel_i,
  input  logic [DATA_W-1:0] mask_data_i,
  input  logic              areg_we_i,
  input  logic [AW-1:0]     areg_i,
  input  logic              wr_i,
  input  logic [1:0]        wr_src_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        wr_vb_i,
  input  logic [1:0]        wr_msel_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rd_vb_o,
  input  logic              cmp_i,
  input  logic [1:0]        cmp_cond_i,
  input  logic [DATA_W-1:0] cmp_key_i,
  output logic              match_o,
  output logic              multi_o,
  output logic [AW-1:0]     hpm_addr_o,
  output logic [AW-1:0]     free_addr_o,
  output logic              full_o
);
  localparam logic [AW:0] N_LIM = (AW+1)'(N_ENTRIES);

  logic [DATA_W-1:0] mem_q [N_ENTRIES];
  logic [1:0]        vb_q  [N_ENTRIES];
  logic [2:0]        part_q;
  msel_e             msel_q;
  logic [DATA_W-1:0] mask_a_q, mask_b_q;
  logic [AW-1:0]     areg_q;
  logic              match_q, multi_q;
  logic [AW-1:0]     hpm_q;

  function automatic logic [DATA_W-1:0] pick_mask(input msel_e s,
                                                  input logic [DATA_W-1:0] ma,
                                                  input logic [DATA_W-1:0] mb);
    case (s)
      MS_A:    return ma;
      MS_B:    return mb;
      default: return '0;
    endcase
  endfunction

  // control and mask registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q   <= 3'b000;
      msel_q   <= MS_NONE;
      mask_a_q <= '0;
      mask_b_q <= '0;
      areg_q   <= '0;
    end else begin
      if (ctrl_we_i) begin
        part_q <= ctrl_part_i;
        msel_q <= msel_e'(ctrl_msel_i);
      end
      if (mask_we_i) begin
        if (mask_sel_i) mask_b_q <= mask_data_i;
        else            mask_a_q <= mask_data_i;
      end
      if (areg_we_i) areg_q <= areg_i;
    end
  end

  // compare path
  logic [DATA_W-1:0] care_bits, ign_bits;
  logic [N_ENTRIES-1:0] hit_vec, empty_vec;
  logic hit_any, free_any;
  logic [AW-1:0] hit_idx, free_idx;
  logic hit_multi;

  tcam_part_mask #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_part (
    .part_i (part_q),
    .care_o (care_bits)
  );

  // empty-condition compares ignore all data
  assign ign_bits = (cmp_cond_i == VB_EMPTY) ? {DATA_W{1'b1}}
                  : (~care_bits | pick_mask(msel_q, mask_a_q, mask_b_q));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_line
    tcam_match_line #(.DATA_W(DATA_W)) u_line (
      .entry_i (mem_q[e]),
      .vb_i    (vb_q[e]),
      .key_i   (cmp_key_i),
      .ign_i   (ign_bits),
      .cond_i  (cmp_cond_i),
      .hit_o   (hit_vec[e])
    );
    assign empty_vec[e] = (vb_q[e] == VB_EMPTY);
  end

  tcam_prio_enc #(.N(N_ENTRIES), .AW(AW)) u_hit_enc (
    .req_i   (hit_vec),
    .found_o (hit_any),
    .idx_o   (hit_idx)
  );

  tcam_prio_enc #(.N(N_ENTRIES), .AW(AW)) u_free_enc (
    .req_i   (empty_vec),
    .found_o (free_any),
    .idx_o   (free_idx)
  );

  assign hit_multi = |(hit_vec & (hit_vec - N_ENTRIES'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      hpm_q   <= '0;
    end else if (cmp_i) begin
      match_q <= hit_any;
      multi_q <= hit_multi;
      hpm_q   <= hit_idx;
    end else if (wr_i) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      hpm_q   <= '0;
    end
  end

  // write path
  logic [AW-1:0]     wr_idx;
  logic              wr_ok, wr_go;
  logic [DATA_W-1:0] wmask;

  always_comb begin
    wr_ok = 1'b1;
    case (wsrc_e'(wr_src_i))
      WA_EXPLICIT: wr_idx = wr_addr_i;
      WA_AREG:     wr_idx = areg_q;
      WA_FREE: begin
        wr_idx = free_idx;
        wr_ok  = free_any;
      end
      default: begin
        wr_idx = hpm_q;
        wr_ok  = match_q;
      end
    endcase
  end

  assign wr_go = wr_i && wr_ok && ({1'b0, wr_idx} < N_LIM);
  assign wmask = pick_mask(msel_e'(wr_msel_i), mask_a_q, mask_b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        mem_q[i] <= '0;
        vb_q[i]  <= VB_EMPTY;
      end
    end else if (wr_go) begin
      mem_q[wr_idx] <= (mem_q[wr_idx] & wmask) | (wr_data_i & ~wmask);
      vb_q[wr_idx]  <= wr_vb_i;
    end
  end

  // outputs
  always_comb begin
    rd_data_o = '0;
    rd_vb_o   = VB_EMPTY;
    if ({1'b0, rd_addr_i} < N_LIM) begin
      rd_data_o = mem_q[rd_addr_i];
      rd_vb_o   = vb_q[rd_addr_i];
    end
  end

  assign match_o     = match_q;
  assign multi_o     = multi_q;
  assign hpm_addr_o  = hpm_q;
  assign free_addr_o = free_idx;
  assign full_o      = ~free_any;

  AST_MULTI_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> match_o); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cmp_i) |=> (!match_o && !multi_o)); // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_i && !wr_i) |=> ($stable(match_o) && $stable(multi_o) && $stable(hpm_addr_o))); // R4
  AST_FREE_IS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> (vb_q[free_addr_o] == VB_EMPTY)); // R11
  AST_FREE_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> ((empty_vec & ((N_ENTRIES'(1) << free_addr_o) - N_ENTRIES'(1))) == '0)); // R11
endmodule

// File: tb/tb_tcam_array.sv
module tb_tcam_array;
  localparam int N  = 16;
  localparam int AW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ctrl_we_i = 0; logic [2:0] ctrl_part_i = 0; logic [1:0] ctrl_msel_i = 0;
  logic mask_we_i = 0; logic mask_sel_i = 0; logic [63:0] mask_data_i = 0;
  logic areg_we_i = 0; logic [AW-1:0] areg_i = 0;
  logic wr_i = 0; logic [1:0] wr_src_i = 0; logic [AW-1:0] wr_addr_i = 0;
  logic [63:0] wr_data_i = 0; logic [1:0] wr_vb_i = 0; logic [1:0] wr_msel_i = 0;
  logic [AW-1:0] rd_addr_i = 0; logic [63:0] rd_data_o; logic [1:0] rd_vb_o;
  logic cmp_i = 0; logic [1:0] cmp_cond_i = 0; logic [63:0] cmp_key_i = 0;
  logic match_o, multi_o, full_o;
  logic [AW-1:0] hpm_addr_o, free_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] DA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DB = 64'hAAAA_BBBB_CCCC_DDDD;
  localparam logic [63:0] DC = 64'h0123_4567_89AB_CDEF;

  always #5 clk_i = ~clk_i;

  tcam_array #(.N_ENTRIES(N), .DATA_W(64), .SEG_W(16)) dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [2:0] part, input logic [1:0] msel);
    @(negedge clk_i); ctrl_we_i = 1; ctrl_part_i = part; ctrl_msel_i = msel;
    @(negedge clk_i); ctrl_we_i = 0;
  endtask

  task automatic set_mask(input logic sel, input logic [63:0] m);
    @(negedge clk_i); mask_we_i = 1; mask_sel_i = sel; mask_data_i = m;
    @(negedge clk_i); mask_we_i = 0;
  endtask

  task automatic wr(input logic [1:0] src, input logic [AW-1:0] a, input logic [63:0] d,
                    input logic [1:0] vb, input logic [1:0] ms);
    @(negedge clk_i); wr_i = 1; wr_src_i = src; wr_addr_i = a; wr_data_i = d; wr_vb_i = vb; wr_msel_i = ms;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic cmp(input logic [1:0] cond, input logic [63:0] key);
    @(negedge clk_i); cmp_i = 1; cmp_cond_i = cond; cmp_key_i = key;
    @(negedge clk_i); cmp_i = 0;
  endtask

  task automatic exp_res(input string req, input logic m, input logic mu, input logic [AW-1:0] h);
    chk(req, "match", 64'(match_o), 64'(m));
    chk(req, "multi", 64'(multi_o), 64'(mu));
    if (m) chk(req, "hpm", 64'(hpm_addr_o), 64'(h));
  endtask

  task automatic exp_rd(input string req, input logic [AW-1:0] a, input logic [63:0] d, input logic [1:0] vb);
    rd_addr_i = a; #1;
    chk(req, "rd_data", rd_data_o, d);
    chk(req, "rd_vb", 64'(rd_vb_o), 64'(vb));
  endtask

  task automatic t_reset;
    chk("R1", "match", 64'(match_o), 0);
    chk("R1", "full", 64'(full_o), 0);
    chk("R1", "free", 64'(free_addr_o), 0);
    exp_rd("R1", 5, 64'h0, 2'b01);
  endtask

  task automatic t_basic;
    wr(2'b00, 0, DA, 2'b00, 2'b00);
    chk("R11", "free after one write", 64'(free_addr_o), 1);
    wr(2'b00, 1, DB, 2'b00, 2'b00);
    wr(2'b00, 2, DC, 2'b00, 2'b00);
    exp_rd("R12", 1, DB, 2'b00);
    cmp(2'b00, DA); exp_res("R3", 1, 0, 0);
    cmp(2'b00, DB); exp_res("R3", 1, 0, 1);
    @(negedge clk_i); @(negedge clk_i);
    exp_res("R4", 1, 0, 1);
    cmp(2'b00, 64'hDEAD); exp_res("R3", 0, 0, 0);
  endtask

  task automatic t_multi;
    wr(2'b00, 5, DA, 2'b00, 2'b00);
    cmp(2'b00, DA); exp_res("R3", 1, 1, 0);
    wr(2'b00, 6, DC, 2'b00, 2'b00);
    chk("R4", "match cleared by write", 64'(match_o), 0);
    chk("R4", "hpm cleared by write", 64'(hpm_addr_o), 0);
    chk("R11", "free gap", 64'(free_addr_o), 3);
  endtask

  task automatic t_validity;
    wr(2'b00, 3, DB, 2'b10, 2'b00);
    wr(2'b00, 4, 64'h5555, 2'b11, 2'b00);
    cmp(2'b00, DB); exp_res("R2", 1, 0, 1);
    cmp(2'b10, DB); exp_res("R2", 1, 0, 3);
    cmp(2'b00, 64'h5555); exp_res("R2", 0, 0, 0);
    cmp(2'b11, 64'h5555); exp_res("R2", 1, 0, 4);
    chk("R11", "free", 64'(free_addr_o), 7);
  endtask

  task automatic t_mask;
    set_mask(0, 64'h0000_0000_0000_FFFF);
    set_ctrl(3'b000, 2'b01);
    cmp(2'b00, 64'h1111_2222_3333_0000); exp_res("R5", 1, 1, 0);
    set_ctrl(3'b000, 2'b00);
    cmp(2'b00, 64'h1111_2222_3333_0000); exp_res("R5", 0, 0, 0);
    set_mask(1, 64'hFFFF_0000_0000_0000);
    set_ctrl(3'b000, 2'b10);
    cmp(2'b00, 64'h0000_BBBB_CCCC_DDDD); exp_res("R5", 1, 0, 1);
    set_ctrl(3'b000, 2'b11);
    cmp(2'b00, 64'h0000_BBBB_CCCC_DDDD); exp_res("R5", 0, 0, 0);
  endtask

  task automatic t_part;
    set_ctrl(3'b001, 2'b00);
    cmp(2'b00, 64'h1111_2222_3333_9999); exp_res("R6", 1, 1, 0);
    set_ctrl(3'b101, 2'b00);
    cmp(2'b00, 64'h7777_2222_3333_4444); exp_res("R6", 1, 1, 0);
    cmp(2'b00, 64'h1111_2222_3333_9999); exp_res("R6", 0, 0, 0);
    set_ctrl(3'b011, 2'b00);
    cmp(2'b00, 64'h0123_0000_0000_0000); exp_res("R6", 1, 1, 2);
    exp_rd("R6", 0, DA, 2'b00);
  endtask

  task automatic t_empty;
    set_ctrl(3'b011, 2'b01);
    cmp(2'b01, 64'hFACE_FACE_FACE_FACE); exp_res("R7", 1, 1, 7);
    set_ctrl(3'b000, 2'b00);
  endtask

  task automatic t_wsrc;
    @(negedge clk_i); areg_we_i = 1; areg_i = 9;
    @(negedge clk_i); areg_we_i = 0;
    wr(2'b01, 0, 64'h9999, 2'b00, 2'b00);
    exp_rd("R8", 9, 64'h9999, 2'b00);
    wr(2'b10, 0, 64'h7777, 2'b00, 2'b00);
    exp_rd("R8", 7, 64'h7777, 2'b00);
    chk("R11", "free", 64'(free_addr_o), 8);
    cmp(2'b00, 64'h7777); exp_res("R3", 1, 0, 7);
    wr(2'b11, 0, 64'h8888, 2'b00, 2'b00);
    exp_rd("R8", 7, 64'h8888, 2'b00);
    wr(2'b11, 0, 64'hDEAD, 2'b00, 2'b00);
    exp_rd("R9", 7, 64'h8888, 2'b00);
    exp_rd("R9", 0, DA, 2'b00);
  endtask

  task automatic t_wmask;
    set_mask(1, 64'h0000_0000_FFFF_FFFF);
    wr(2'b00, 0, 64'hEEEE_EEEE_EEEE_EEEE, 2'b00, 2'b10);
    exp_rd("R10", 0, 64'hEEEE_EEEE_3333_4444, 2'b00);
    wr(2'b00, 1, 64'hEEEE_EEEE_EEEE_EEEE, 2'b00, 2'b01);
    exp_rd("R10", 1, 64'hEEEE_EEEE_EEEE_DDDD, 2'b00);
  endtask

  task automatic t_full;
    for (int k = 0; k < 7; k++) wr(2'b10, 0, 64'hF000 + 64'(k), 2'b00, 2'b00);
    chk("R11", "full", 64'(full_o), 1);
    exp_rd("R8", 8, 64'hF000, 2'b00);
    exp_rd("R8", 15, 64'hF006, 2'b00);
    wr(2'b10, 0, 64'hBAD, 2'b00, 2'b00);
    exp_rd("R9", 15, 64'hF006, 2'b00);
    exp_rd("R9", 0, 64'hEEEE_EEEE_3333_4444, 2'b00);
    chk("R9", "still full", 64'(full_o), 1);
    cmp(2'b01, 64'h0); exp_res("R7", 0, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_multi();
    t_validity();
    t_mask();
    t_part();
    t_empty();
    t_wsrc();
    t_wmask();
    t_full();
    finish_run();
  end
endmodule